// File: doc/BRIEF.md
# LFSR-Coded Fractional Clock Generator

This block is a bank of independent fractional clock generators. Each channel makes an output clock whose period is counted in ticks of a reference strobe that runs at twice the reference rate. The period is an integer divide value N, plus one extra tick on some periods. The choice of which periods get the extra tick comes from a first-order sigma-delta accumulator. That accumulator is driven by two signed increments, so the average period is N + inc1/(inc1 − inc2) ticks.

The coarse part of N is stored as a state of an 11-bit Galois LFSR rather than as a binary number. The channel never turns that state into binary. It walks the LFSR from the stored state back to the all-ones seed, once for the high phase and once for the low phase of every period, and spends two ticks per LFSR step. A short binary prefix holds the constant part of N and the fine bits.

Software programs each channel through a word-addressed register window of 0x4000 bytes. The expected sequence is to clear the enable, write the divider and both increments, then set the enable again.

Top module: `lfsr_frac_clkgen`

## Requirements
- R1: Channel k decodes addresses k*0x4000 + {0x0 control, 0x4 divider, 0x8 increment 1, 0xC increment 2}. All registers reset to 0. A read returns the full 32-bit word last written, on rdata in the same cycle as the address. Writes to any other offset change nothing, and reads of any other offset return 0.
- R2: Control bit 31 enables the channel. When it is 0, clk_out for that channel is 0 from the cycle after the write edge onward.
- R3: Divider bits [12:2] hold a coarse LFSR state S, and bits [1:0] hold a fine count F. Let idx be the index at which S appears in the sequence defined in R4. Then N = 4*(idx+2) + F.
- R4: The LFSR steps by shifting right one place and XORing 0x500 into the result when the bit shifted out was 1. Starting from 0x7FF, the state reached after k steps (k = 1..2047) has index 0x800 − k. Each output period lasts N or N+1 ticks.
- R5: Each period starts with a rising edge of clk_out. The output stays high for floor(P/2) ticks and low for the remaining ticks, where P is that period's length.
- R6: A signed accumulator starts at 0 whenever a channel starts. At each period start, if it is ≥ 0 the period is N+1 ticks and increment 2 is added to it; otherwise the period is N ticks and increment 1 is added.
- R7: If increment 1 is negative, or increment 2 is positive, or both are zero, or the coarse state is 0, the channel produces no output (clk_out stays 0).
- R8: Only clock cycles with tick = 1 count as units. clk_out changes only at an edge where tick = 1, apart from a stop or restart.
- R9: With tick held at 1, clk_out rises exactly one clock edge after the edge that stores the enabling write.
- R10: Any write to a channel's registers restarts that channel: clk_out goes to 0 after the write edge, and the accumulator and LFSR start over. Other channels are not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counting strobe, one unit (half a reference cycle) per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | WIN_BITS+CH_W | Byte address: channel select above the window bits |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| clk_out | output | NCH | Generated clock, one bit per channel |

## Verification
A register write takes effect at the clock edge on which wr_en is sampled. Read data follows addr without a register, so the bench samples rdata 1 ns after it sets the address. A stop or restart lands one edge after the write edge, and with tick held high the first rising edge also comes one edge later. The bench therefore samples clk_out at the falling edge right after its write task returns, and again one falling edge after that. Period and duty are checked by counting falling-edge samples between rising edges of clk_out. Each counted period is compared against a period list that the bench computes from its own LFSR walk and accumulator model, scaled by the tick spacing.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int REG_W    = 32;
  localparam int LFSR_W   = 11;
  localparam int FINE_W   = 2;
  localparam int FRAC_W   = FINE_W + 1;
  localparam int PRE_W    = 4;
  localparam int EN_BIT   = 31;
  localparam int COARSE_LSB = FINE_W;

  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;
  localparam logic [LFSR_W-1:0] LFSR_FEED = 11'h500;
  // constant part of each half period: 2*(2+1) ticks
  localparam logic [PRE_W-1:0]  PRE_BASE  = 4'd6;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_INC1 = 2'd2,
    SEL_INC2 = 2'd3
  } reg_sel_e;

  // one Galois step, shift right, feed taps when a one falls out
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_FEED : '0);
  endfunction

  // prefix ticks for the high half: floor(frac/2) on top of the base
  function automatic logic [PRE_W-1:0] hi_prefix(input logic [FRAC_W-1:0] frac);
    return PRE_BASE + PRE_W'(frac >> 1);
  endfunction

  // prefix ticks for the low half: ceil(frac/2) on top of the base
  function automatic logic [PRE_W-1:0] lo_prefix(input logic [FRAC_W-1:0] frac);
    return PRE_BASE + PRE_W'((frac + 3'd1) >> 1);
  endfunction

  function automatic logic incs_ok(input logic signed [REG_W-1:0] up,
                                   input logic signed [REG_W-1:0] dn);
    return !up[REG_W-1] && (dn[REG_W-1] || dn == '0) && !(up == '0 && dn == '0);
  endfunction
endpackage

// File: rtl/nco_regfile.sv
module nco_regfile import nco_pkg::*; #(
  parameter int NCH      = 2,
  parameter int WIN_BITS = 14,
  parameter int CH_W     = 1,
  parameter int ADDR_W   = WIN_BITS + CH_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [REG_W-1:0]            wdata,
  output logic [REG_W-1:0]            rdata,
  output logic [NCH-1:0]              ch_enable,
  output logic [NCH-1:0][LFSR_W-1:0]  ch_coarse,
  output logic [NCH-1:0][FINE_W-1:0]  ch_fine,
  output logic [NCH-1:0][REG_W-1:0]   ch_inc1,
  output logic [NCH-1:0][REG_W-1:0]   ch_inc2,
  output logic [NCH-1:0]              ch_wr_hit
);
  logic [REG_W-1:0] regs [NCH][4];
  logic [CH_W-1:0]  sel_ch;
  logic [1:0]       sel_reg;
  logic             in_map;

  assign sel_ch  = addr[ADDR_W-1:WIN_BITS];
  assign sel_reg = addr[3:2];
  assign in_map  = (addr[WIN_BITS-1:4] == '0) && (addr[1:0] == 2'b00) &&
                   (32'(sel_ch) < NCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < 4; r++)
          regs[c][r] <= '0;
    end else if (wr_en && in_map) begin
      regs[sel_ch][sel_reg] <= wdata;
    end
  end

  assign rdata = in_map ? regs[sel_ch][sel_reg] : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_fields
    assign ch_enable[g] = regs[g][SEL_CTRL][EN_BIT];
    assign ch_coarse[g] = regs[g][SEL_DIV][COARSE_LSB +: LFSR_W];
    assign ch_fine[g]   = regs[g][SEL_DIV][FINE_W-1:0];
    assign ch_inc1[g]   = regs[g][SEL_INC1];
    assign ch_inc2[g]   = regs[g][SEL_INC2];
    assign ch_wr_hit[g] = wr_en && in_map && (32'(sel_ch) == g);
  end
endmodule

// File: rtl/nco_sd_accum.sv
module nco_sd_accum import nco_pkg::*; #(
  parameter int ACC_W = REG_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    step,
  input  logic signed [REG_W-1:0] inc_up,
  input  logic signed [REG_W-1:0] inc_dn,
  output logic                    stretch
);
  logic signed [ACC_W-1:0] acc_q;

  // stays within [inc_dn, inc_up), so one guard bit is enough
  function automatic logic signed [ACC_W-1:0] sd_update(
    input logic signed [ACC_W-1:0] acc,
    input logic signed [REG_W-1:0] up,
    input logic signed [REG_W-1:0] dn);
    if (!acc[ACC_W-1]) return acc + ACC_W'(dn);
    else               return acc + ACC_W'(up);
  endfunction

  assign stretch = !acc_q[ACC_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (step)  acc_q <= sd_update(acc_q, inc_up, inc_dn);
  end
endmodule

// File: rtl/nco_lfsr_phase.sv
module nco_lfsr_phase import nco_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              adv,
  input  logic [PRE_W-1:0]  load_pre,
  input  logic [LFSR_W-1:0] coarse,
  output logic              expire
);
  logic [PRE_W-1:0]  pre_q, pre_n;
  logic              half_q, half_n;
  logic [LFSR_W-1:0] lf_q, lf_n;

  // consume one tick: prefix first, then two ticks per LFSR step
  always_comb begin
    pre_n  = pre_q;
    half_n = half_q;
    lf_n   = lf_q;
    if (pre_q != '0) begin
      pre_n = pre_q - 1'b1;
    end else if (!half_q) begin
      half_n = 1'b1;
    end else begin
      half_n = 1'b0;
      lf_n   = lfsr_next(lf_q);
    end
  end

  assign expire = (pre_n == '0) && !half_n && (lf_n == LFSR_SEED);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pre_q  <= '0;
      half_q <= 1'b0;
      lf_q   <= LFSR_SEED;
    end else if (load) begin
      pre_q  <= load_pre;
      half_q <= 1'b0;
      lf_q   <= coarse;
    end else if (adv) begin
      pre_q  <= pre_n;
      half_q <= half_n;
      lf_q   <= lf_n;
    end
  end
endmodule

// File: rtl/nco_channel.sv
module nco_channel import nco_pkg::*; (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    enable,
  input  logic                    wr_hit,
  input  logic [LFSR_W-1:0]       coarse,
  input  logic [FINE_W-1:0]       fine,
  input  logic signed [REG_W-1:0] inc1,
  input  logic signed [REG_W-1:0] inc2,
  output logic                    clk_out,
  output logic                    run,
  output logic                    period_start,
  output logic                    hi_end
);
  logic              active_q, hi_q;
  logic [FRAC_W-1:0] frac_q, frac_new;
  logic              stretch, expire, clear, phase_end;
  logic [PRE_W-1:0]  pre_sel;

  assign run          = enable && incs_ok(inc1, inc2) && (coarse != '0);
  assign clear        = !run || wr_hit;
  assign phase_end    = active_q && tick && expire;
  assign hi_end       = phase_end && hi_q;
  assign period_start = !clear && tick && (!active_q || (phase_end && !hi_q));
  assign frac_new     = FRAC_W'(fine) + FRAC_W'(stretch);
  assign pre_sel      = period_start ? hi_prefix(frac_new) : lo_prefix(frac_q);

  nco_lfsr_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .load     (period_start || hi_end),
    .adv      (active_q && tick),
    .load_pre (pre_sel),
    .coarse   (coarse),
    .expire   (expire)
  );

  nco_sd_accum u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .step    (period_start),
    .inc_up  (inc1),
    .inc_dn  (inc2),
    .stretch (stretch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      active_q <= 1'b0;
      hi_q     <= 1'b0;
      frac_q   <= '0;
    end else if (period_start) begin
      active_q <= 1'b1;
      hi_q     <= 1'b1;
      frac_q   <= frac_new;
    end else if (hi_end) begin
      hi_q     <= 1'b0;
    end
  end

  assign clk_out = active_q && hi_q;
endmodule

// File: rtl/lfsr_frac_clkgen.sv
module lfsr_frac_clkgen import nco_pkg::*; #(
  parameter int  NCH      = 2,
  parameter int  WIN_BITS = 14,
  localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W   = WIN_BITS + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [NCH-1:0]    clk_out
);
  logic [NCH-1:0]             ch_enable, ch_wr_hit;
  logic [NCH-1:0][LFSR_W-1:0] ch_coarse;
  logic [NCH-1:0][FINE_W-1:0] ch_fine;
  logic [NCH-1:0][REG_W-1:0]  ch_inc1, ch_inc2;
  logic [NCH-1:0]             ch_run, ch_start, ch_hi_end;

  nco_regfile #(
    .NCH(NCH), .WIN_BITS(WIN_BITS), .CH_W(CH_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .ch_enable (ch_enable),
    .ch_coarse (ch_coarse),
    .ch_fine   (ch_fine),
    .ch_inc1   (ch_inc1),
    .ch_inc2   (ch_inc2),
    .ch_wr_hit (ch_wr_hit)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    nco_channel u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .enable       (ch_enable[g]),
      .wr_hit       (ch_wr_hit[g]),
      .coarse       (ch_coarse[g]),
      .fine         (ch_fine[g]),
      .inc1         (ch_inc1[g]),
      .inc2         (ch_inc2[g]),
      .clk_out      (clk_out[g]),
      .run          (ch_run[g]),
      .period_start (ch_start[g]),
      .hi_end       (ch_hi_end[g])
    );
  end
endmodule

// File: rtl/lfsr_frac_clkgen_chk.sv
module lfsr_frac_clkgen_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           wr_en,
  input logic [NCH-1:0] clk_out,
  input logic [NCH-1:0] run,
  input logic [NCH-1:0] start,
  input logic [NCH-1:0] hi_end,
  input logic [NCH-1:0] wr_hit
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n) !run[i] |=> !clk_out[i]); // R2 R7
    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n) start[i] |=> clk_out[i]); // R5
    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(clk_out[i]) |-> $past(start[i])); // R5
    AST_FALL_AT_HI_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(clk_out[i]) |-> $past(hi_end[i] || !run[i] || wr_hit[i])); // R5
    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n) (!tick && run[i] && !wr_en) |=> $stable(clk_out[i])); // R8
    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n) wr_hit[i] |=> !clk_out[i]); // R10
  end
endmodule

bind lfsr_frac_clkgen lfsr_frac_clkgen_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .wr_en   (wr_en),
  .clk_out (clk_out),
  .run     (ch_run),
  .start   (ch_start),
  .hi_end  (ch_hi_end),
  .wr_hit  (ch_wr_hit)
);

// File: tb/lfsr_frac_clkgen_bench.sv
module lfsr_frac_clkgen_bench;
  localparam int NCH = 2;
  localparam int AW  = 15;

  logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  wire  [31:0]   rdata;
  wire  [NCH-1:0] clk_out;

  int checks = 0, failures = 0;
  int tick_div = 1, tick_cnt = 0;

  lfsr_frac_clkgen #(.NCH(NCH)) u_lfsr_frac_clkgen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .clk_out(clk_out)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (tick_div <= 1) tick <= 1'b1;
    else begin
      tick     <= (tick_cnt == 0);
      tick_cnt <= (tick_cnt + 1) % tick_div;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  // restated step: xor the full 12-bit polynomial, then shift
  function automatic logic [10:0] bstep(input logic [10:0] s);
    logic [11:0] w;
    w = {1'b0, s};
    if (s[0]) w = w ^ 12'hA01;
    return w[11:1];
  endfunction

  function automatic logic [10:0] state_at(input int idx);
    logic [10:0] s;
    s = 11'h7FF;
    for (int i = 'h7FF; i > 0; i--) begin
      s = bstep(s);
      if (i == idx) return s;
    end
    return 11'h000;
  endfunction

  task automatic wr(input int ch, input int off, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(ch * 'h4000 + off); wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [31:0] v);
    @(negedge clk);
    addr = AW'(ch * 'h4000 + off);
    #1 v = rdata;
  endtask

  task automatic prog(input int ch, input logic [10:0] c, input int fine,
                      input longint i1, input longint i2);
    wr(ch, 0, 32'h0);
    wr(ch, 4, {19'b0, c, 2'(fine)});
    wr(ch, 8, 32'(i1));
    wr(ch, 12, 32'(i2));
    wr(ch, 0, 32'h8000_0000);
  endtask

  // count periods from the first rise; bench-side accumulator model
  task automatic measure(input int ch, input int idx, input int fine,
                         input longint i1, input longint i2, input int nper,
                         input int td);
    longint acc;
    int     guard, hi, lo, p;
    bit     other_hi;
    acc = 0; guard = 0; other_hi = 0;
    while (clk_out[ch] !== 1'b1 && guard < 64) begin
      @(negedge clk); guard++;
    end
    chk(clk_out[ch] === 1'b1, "R5 channel starts", guard, 0);
    for (int k = 0; k < nper; k++) begin
      if (acc >= 0) begin p = 4 * (idx + 2) + fine + 1; acc = acc + i2; end
      else          begin p = 4 * (idx + 2) + fine;     acc = acc + i1; end
      hi = 0; lo = 0;
      while (clk_out[ch] === 1'b1 && hi < 20000) begin
        if (clk_out[1-ch] === 1'b1) other_hi = 1;
        hi++; @(negedge clk);
      end
      while (clk_out[ch] === 1'b0 && lo < 20000) begin
        if (clk_out[1-ch] === 1'b1) other_hi = 1;
        lo++; @(negedge clk);
      end
      chk(hi == (p / 2) * td, "R5 high time", hi, (p / 2) * td);
      chk(hi + lo == p * td, "R3/R4/R6 period length", hi + lo, p * td);
    end
    chk(!other_hi, "R10 idle channel unaffected", other_hi, 0);
  endtask

  task automatic idle_check(input int ch, input int ncyc, input string what);
    int highs;
    highs = 0;
    for (int n = 0; n < ncyc; n++) begin
      @(negedge clk);
      if (clk_out[ch] !== 1'b0) highs++;
    end
    chk(highs == 0, what, highs, 0);
  endtask

  initial begin
    logic [31:0] v;
    int idx_l[4];
    longint up_l[4], dn_l[4];
    idx_l = '{1, 2, 3, 6};
    up_l  = '{3, 0, 4, 1};
    dn_l  = '{-5, -7, 0, -1};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clk_out === 2'b00, "R1 outputs low after reset", clk_out, 0);
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < 16; o += 4) begin
        rd(c, o, v);
        chk(v === 32'h0, "R1 reset value", v, 0);
      end

    // R1 readback of full words, then an off-map write
    wr(1, 0, 32'h0000_1234);
    wr(1, 4, 32'hDEAD_BEEF);
    wr(1, 8, 32'h7654_3210);
    wr(1, 12, 32'h8000_0001);
    rd(1, 0, v);  chk(v === 32'h0000_1234, "R1 readback control", v, 32'h1234);
    rd(1, 4, v);  chk(v === 32'hDEAD_BEEF, "R1 readback divider", v, 32'hDEAD_BEEF);
    rd(1, 8, v);  chk(v === 32'h7654_3210, "R1 readback inc1", v, 32'h7654_3210);
    rd(1, 12, v); chk(v === 32'h8000_0001, "R1 readback inc2", v, 32'h8000_0001);
    rd(0, 4, v);  chk(v === 32'h0, "R1 other channel untouched", v, 0);
    wr(0, 'h10, 32'hFFFF_FFFF);
    rd(0, 'h10, v); chk(v === 32'h0, "R1 off-map offset reads zero", v, 0);
    for (int o = 0; o < 16; o += 4) begin
      rd(0, o, v);
      chk(v === 32'h0, "R1 off-map write ignored", v, 0);
    end
    wr(1, 0, 32'h0);

    // R9 start latency with tick always high
    prog(0, state_at(2), 0, 1, -1);
    chk(clk_out[0] === 1'b0, "R9 low right after enabling edge", clk_out[0], 0);
    @(negedge clk);
    chk(clk_out[0] === 1'b1, "R9 high one edge later", clk_out[0], 1);
    repeat (30) @(negedge clk);
    // R2 disable
    wr(0, 0, 32'h0);
    chk(clk_out[0] === 1'b0, "R2 low after disable", clk_out[0], 0);
    idle_check(0, 60, "R2 stays low while disabled");

    // sweep coarse index, fine count and increment pairs
    for (int a = 0; a < 4; a++)
      for (int f = 0; f < 4; f++)
        for (int q = 0; q < 4; q++) begin
          int ch;
          ch = (a + f + q) % 2;
          prog(ch, state_at(idx_l[a]), f, up_l[q], dn_l[q]);
          measure(ch, idx_l[a], f, up_l[q], dn_l[q], 8, 1);
          wr(ch, 0, 32'h0);
        end

    // largest coarse index
    prog(1, state_at(2047), 3, 1, -2);
    measure(1, 2047, 3, 1, -2, 3, 1);
    wr(1, 0, 32'h0);

    // R8 tick every second clock: all times double
    tick_div = 2;
    prog(0, state_at(2), 1, 2, -3);
    measure(0, 2, 1, 2, -3, 6, 2);
    wr(0, 0, 32'h0);
    tick_div = 1;
    repeat (4) @(negedge clk);

    // R10 write while running restarts from a cleared accumulator
    prog(1, state_at(3), 2, 2, -5);
    measure(1, 3, 2, 2, -5, 3, 1);
    wr(1, 8, 32'd2);
    chk(clk_out[1] === 1'b0, "R10 low after write to running channel", clk_out[1], 0);
    measure(1, 3, 2, 2, -5, 5, 1);
    wr(1, 0, 32'h0);

    // R7 invalid settings give no output
    prog(0, state_at(3), 1, -1, -1);
    idle_check(0, 80, "R7 negative inc1");
    prog(0, state_at(3), 1, 1, 1);
    idle_check(0, 80, "R7 positive inc2");
    prog(0, state_at(3), 1, 0, 0);
    idle_check(0, 80, "R7 both increments zero");
    prog(0, 11'h000, 1, 1, -1);
    idle_check(0, 80, "R7 coarse state zero");
    wr(0, 0, 32'h0);

    summary();
    $finish;
  end
endmodule